// File: doc/BRIEF.md
# Two-Channel Output-Compare Timer

This block is a bus-clocked up-counter with a programmable wrap limit, advanced by a power-of-two prescaler. Two compare channels watch the count. Each channel has its own compare value and its own output pin. A channel raises a flag when the count matches its compare value, and it can set, clear or toggle its pin at that moment. A further flag is raised each time the counter wraps. Every flag has an interrupt enable and is cleared by software writing a one to it.

Compare values are unbuffered: a write takes effect on the next clock edge. If software writes a value that the counter has already passed in the current period, that period has no match. Software that changes compare values while the counter runs has to time its writes against the flags. Configuration goes through a single-cycle write port. The block has no read path, so the count, the flags, the interrupt requests and the pins are brought out directly.

Top module: `tmr2ch`

## Requirements
- R1: While running with a one-tick-per-clock rate, `count` steps 0, 1, ..., LIMIT, 0, ... where LIMIT is the value written at address 1; the counter wraps to 0 on the tick that follows the one on which it held LIMIT.
- R2: `ovf_flag` is set by the tick on which the counter wraps from LIMIT to 0. `irq_ovf` equals `ovf_flag` AND the overflow enable (control bit 5, address 0).
- R3: The rate field (control bits 4:2) divides the clock by 2^rate: after n clocks from a cleared prescaler, the counter has advanced floor(n / 2^rate) ticks.
- R4: While the halt bit (control bit 0) is 1, the counter and prescaler hold their values. After reset the halt bit is 1, LIMIT is all ones, the compare values are all ones, and every flag, pin and interrupt request is 0.
- R5: Writing control bit 1 as 1 clears the counter and prescaler on the following clock edge. The bit then returns to 0 by itself.
- R6: Channel i (cfg at address 3+2i, compare at 4+2i) sets `ch_flag[i]` on each tick made while `count` equals its compare value. This happens for every pin action, including hold.
- R7: On a match, the channel's pin action field (cfg bits 1:0) acts on `ch_pin[i]`: 00 holds the pin, 01 toggles it, 10 drives it to 0, 11 drives it to 1.
- R8: With toggle-on-wrap (cfg bit 2) set and a pin action other than 00, the pin inverts on each counter wrap. When a match and a wrap fall on the same tick, the match action is applied first and the inversion second.
- R9: With force-high (cfg bit 3) set, `ch_pin[i]` is 1 from the next edge on, whatever the matches do.
- R10: Writing a 1 to a status bit at address 2 (bit 0 wrap flag, bits 1 and 2 channel flags) clears that flag. Bits written as 0 leave their flags unchanged, and a flag that is being set on the same edge stays set.
- R11: `irq_ch[i]` equals `ch_flag[i]` AND the channel's interrupt enable (cfg bit 4).
- R12: A compare write replaces the active value on the next edge. A new value that is below the current count produces no match until the counter reaches it in the following period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Current counter value |
| ovf_flag | output | 1 | Wrap flag |
| ch_flag | output | 2 | Channel match flags |
| irq_ovf | output | 1 | Wrap interrupt request |
| irq_ch | output | 2 | Channel interrupt requests |
| ch_pin | output | 2 | Channel output pins |

## Verification
On every cycle, the assertions check the counter's step and wrap rule, the freeze while halted, the clear after a restart, the flag that follows a match tick, force-high, and the rule that each interrupt request implies its flag. Only the bench scenarios show the following: the prescaler ratios over long runs, the pin-action sequence across several periods, the order in which a match and a wrap act on the same tick, write-one-to-clear, and the period lost when the compare value is lowered behind the counter.

// File: rtl/tmr2ch.sv
module tmr2ch #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic [1:0]       ch_flag,
  output logic             irq_ovf,
  output logic [1:0]       irq_ch,
  output logic [1:0]       ch_pin
);
  localparam int PS_W = (1 << SEL_W) - 1;
  localparam int NCH  = 2;

  logic                       halt, restart_q, ovf_ie;
  logic [SEL_W-1:0]           rate;
  logic [PS_W-1:0]            ps, ps_mask;
  logic [CNT_W-1:0]           limit;
  logic [NCH-1:0][CNT_W-1:0]  cmp;
  logic [NCH-1:0][1:0]        act;
  logic [NCH-1:0]             tov, maxd, ch_ie, match, pin_nxt;
  logic                       tick, wrap;

  assign ps_mask = (PS_W'(1) << rate) - PS_W'(1);
  assign tick    = !halt && !restart_q && ((ps & ps_mask) == ps_mask);
  assign wrap    = tick && (count == limit);
  assign irq_ovf = ovf_flag & ovf_ie;
  assign irq_ch  = ch_flag & ch_ie;

  wire wr_ctrl = wr_en && wr_addr == 3'd0;
  wire wr_lim  = wr_en && wr_addr == 3'd1;
  wire wr_stat = wr_en && wr_addr == 3'd2;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign match[i] = tick && (count == cmp[i]);
    always_comb begin
      logic p;
      p = ch_pin[i];
      if (match[i]) begin
        case (act[i])
          2'b01:   p = ~p;
          2'b10:   p = 1'b0;
          2'b11:   p = 1'b1;
          default: p = p;
        endcase
      end
      if (wrap && tov[i] && act[i] != 2'b00) p = ~p;
      pin_nxt[i] = maxd[i] ? 1'b1 : p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt      <= 1'b1;
      restart_q <= 1'b0;
      ovf_ie    <= 1'b0;
      rate      <= '0;
      limit     <= '1;
      ps        <= '0;
      count     <= '0;
      ovf_flag  <= 1'b0;
      cmp       <= '1;
      act       <= '0;
      tov       <= '0;
      maxd      <= '0;
      ch_ie     <= '0;
      ch_flag   <= '0;
      ch_pin    <= '0;
    end else begin
      restart_q <= wr_ctrl && wr_data[1];
      if (wr_ctrl) begin
        halt   <= wr_data[0];
        rate   <= wr_data[2 +: SEL_W];
        ovf_ie <= wr_data[5];
      end
      if (wr_lim) limit <= wr_data;
      if (restart_q) begin
        ps    <= '0;
        count <= '0;
      end else if (!halt) begin
        ps <= ps + PS_W'(1);
        if (tick) count <= wrap ? '0 : count + CNT_W'(1);
      end
      ovf_flag <= wrap | (ovf_flag & ~(wr_stat & wr_data[0]));
      for (int i = 0; i < NCH; i++) begin
        if (wr_en && wr_addr == 3'(3 + 2 * i)) begin
          act[i]   <= wr_data[1:0];
          tov[i]   <= wr_data[2];
          maxd[i]  <= wr_data[3];
          ch_ie[i] <= wr_data[4];
        end
        if (wr_en && wr_addr == 3'(4 + 2 * i)) cmp[i] <= wr_data;
        ch_flag[i] <= match[i] | (ch_flag[i] & ~(wr_stat & wr_data[1 + i]));
        ch_pin[i]  <= pin_nxt[i];
      end
    end
  end
endmodule

module tmr2ch_chk #(
  parameter int CNT_W = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick,
  input logic                      halt,
  input logic                      restart_q,
  input logic [CNT_W-1:0]          count,
  input logic [CNT_W-1:0]          limit,
  input logic [1:0][CNT_W-1:0]     cmp,
  input logic [1:0]                maxd,
  input logic                      ovf_flag,
  input logic [1:0]                ch_flag,
  input logic                      irq_ovf,
  input logic [1:0]                irq_ch,
  input logic [1:0]                ch_pin
);
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick && count != limit |=> count == $past(count) + CNT_W'(1));
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick && count == limit |=> count == '0 && ovf_flag);
  a_r2_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> ovf_flag);
  a_r4_halt: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !restart_q |=> $stable(count));
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart_q |=> count == '0);
  a_r6_flag0: assert property (@(posedge clk) disable iff (!rst_n)
    tick && count == cmp[0] |=> ch_flag[0]);
  a_r6_flag1: assert property (@(posedge clk) disable iff (!rst_n)
    tick && count == cmp[1] |=> ch_flag[1]);
  a_r9_force0: assert property (@(posedge clk) disable iff (!rst_n)
    maxd[0] |=> ch_pin[0]);
  a_r9_force1: assert property (@(posedge clk) disable iff (!rst_n)
    maxd[1] |=> ch_pin[1]);
  a_r11_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ch & ~ch_flag) == 2'b00);
endmodule

bind tmr2ch tmr2ch_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt), .restart_q(restart_q),
  .count(count), .limit(limit), .cmp(cmp), .maxd(maxd), .ovf_flag(ovf_flag),
  .ch_flag(ch_flag), .irq_ovf(irq_ovf), .irq_ch(irq_ch), .ch_pin(ch_pin)
);

// File: tb/test_tmr2ch.sv
module test_tmr2ch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        ovf_flag, irq_ovf;
  logic [1:0]  ch_flag, irq_ch, ch_pin;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tmr2ch i_tmr2ch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .ovf_flag(ovf_flag), .ch_flag(ch_flag), .irq_ovf(irq_ovf),
    .irq_ch(irq_ch), .ch_pin(ch_pin)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    bit p0, p1, f0, f1;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 reset count", count, 0);
    chk("R4 reset flags", {ovf_flag, ch_flag, irq_ovf, irq_ch}, 0);
    chk("R4 reset pins", ch_pin, 0);

    // R1 R2: limit 9, one tick per clock, wrap interrupt enabled
    wr(3'd1, 16'd9);
    wr(3'd0, 16'h0020);
    for (int n = 1; n <= 25; n++) begin
      @(negedge clk);
      chk("R1 count", count, n % 10);
      chk("R2 ovf_flag", ovf_flag, n >= 10);
      chk("R2 irq_ovf", irq_ovf, n >= 10);
    end
    wr(3'd2, 16'h0001);
    chk("R10 clear wrap flag", ovf_flag, 0);

    // R3 R5: rate sweep from a cleared prescaler
    for (int s = 0; s < 4; s++) begin
      wr(3'd0, 16'(3 | (s << 2)));
      wr(3'd0, 16'(s << 2));
      chk("R5 restart", count, 0);
      for (int n = 1; n <= 24; n++) begin
        @(negedge clk);
        chk("R3 rate", count, (n >> s) % 10);
      end
    end

    // R4 halt freezes
    wr(3'd0, 16'h0001);
    held = count;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      chk("R4 halt", count, held);
    end

    // R6 R7 R8 R11: ch0 toggle at 4 with irq, ch1 clear at 6 with toggle-on-wrap
    wr(3'd0, 16'h0003);
    wr(3'd2, 16'h0007);
    wr(3'd4, 16'd4);
    wr(3'd3, 16'h0011);
    wr(3'd6, 16'd6);
    wr(3'd5, 16'h0006);
    wr(3'd0, 16'h0000);
    p0 = 0; p1 = 0; f0 = 0; f1 = 0;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if ((n - 1) % 10 == 4) begin p0 = ~p0; f0 = 1; end
      if ((n - 1) % 10 == 6) begin p1 = 0; f1 = 1; end
      if ((n - 1) % 10 == 9) p1 = ~p1;
      chk("R7 pin0 toggle", ch_pin[0], p0);
      chk("R8 pin1 clear+wrap toggle", ch_pin[1], p1);
      chk("R6 flags", ch_flag, {f1, f0});
      chk("R11 irq", irq_ch, {1'b0, f0});
    end
    wr(3'd2, 16'h0002);
    chk("R10 clear ch0 only", ch_flag, 2'b10);

    // R7 hold on ch0, R8 match and wrap on the same tick for ch1
    wr(3'd0, 16'h0003);
    wr(3'd2, 16'h0007);
    wr(3'd4, 16'd2);
    wr(3'd3, 16'h0004);
    wr(3'd6, 16'd9);
    wr(3'd5, 16'h0007);
    wr(3'd0, 16'h0000);
    for (int n = 1; n <= 10; n++) begin
      @(negedge clk);
      chk("R7 hold pin0", ch_pin[0], 0);
      chk("R6 flag with hold", ch_flag[0], n >= 3);
      chk("R8 same-tick order", ch_pin[1], n < 10);
    end

    // R9 force high on ch1 while clear action matches
    wr(3'd5, 16'h000A);
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      chk("R9 force high", ch_pin[1], 1);
    end

    // R12 lowering compare behind the counter loses the period
    wr(3'd0, 16'h0003);
    wr(3'd5, 16'h0000);
    wr(3'd2, 16'h0007);
    wr(3'd4, 16'd8);
    wr(3'd3, 16'h0001);
    wr(3'd0, 16'h0000);
    repeat (5) @(negedge clk);
    chk("R12 setup count", count, 5);
    wr(3'd4, 16'd3);
    for (int n = 7; n <= 13; n++) begin
      @(negedge clk);
      chk("R12 no match", ch_flag[0], 0);
    end
    @(negedge clk);
    chk("R12 match next period", ch_flag[0], 1);
    summary();
  end
endmodule